// File: doc/BRIEF.md
# Comparator-Triggered Complementary Switch Driver

This block generates the gate-drive pair for one phase of a critical-conduction-mode boost converter. It has no free-running timebase. The two digital comparator flags decide when the main switch turns on and when it turns off. One flag says the sensed current is above the command threshold. The other says the current has dropped below the zero threshold.

Each flag can be inverted, so the same configuration serves both AC half-cycles. Each flag is then synchronized and reduced to a single-cycle event. Two event slots, T1 and T2, each choose one of the two flags as their source and apply an action to the switch state. The switch state goes through a dead-band stage, which produces complementary outputs A and B. A programmable rising-edge delay on A stretches the period for light-load discontinuous operation. A falling-edge delay on B provides the gap between the two outputs.

A latched trip stage comes after the dead-band. It overrides both outputs with no added delay.

Several instances can share the same comparator source. Their latency is fixed, so all such phases switch in the same cycle.

Top module: `cmp_pwm_stage`

## Requirements
- R1: After reset, output A is low, output B is high and no trip is latched.
- R2: A comparator level that newly becomes asserted (after inversion) produces exactly one event, and the resulting switch change appears at the outputs after the third rising clock edge that samples the new level.
- R3: Setting a flag's inversion bit makes a falling comparator level the event. Changing inversion and level together so that the inverted level is unchanged produces no event.
- R4: Action codes are 2'b00 none, 2'b01 clear, 2'b10 set, 2'b11 toggle. The T1/T2 source select is 0 for the high-threshold flag and 1 for the low-threshold flag. With the usual setting, T1 takes the high flag with clear and T2 takes the low flag with set.
- R5: When T1 and T2 events fall in the same cycle, the T2 action wins unless it is none, in which case the T1 action applies.
- R6: Output A rises red_i clock cycles after the switch state rises. A value of zero passes the edge straight through.
- R7: If the switch state falls while the rising-edge delay is still counting, the pending rise of A is cancelled and A stays low.
- R8: Output B falls in the same cycle the switch state rises. B rises fed_i cycles after the switch state falls. A and B are never high together outside a trip.
- R9: While trip_i is high, A is forced low and B is forced to trip_b_lvl_i in the same cycle, bypassing the dead-band delays.
- R10: A trip stays latched after trip_i drops. It is released only by trip_clr_i sampled while trip_i is low, and normal outputs then resume on the next cycle.
- R11: Instances fed by the same comparator event switch their A outputs in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_hi_i | input | 1 | Current above command threshold flag |
| cmp_lo_i | input | 1 | Current below zero threshold flag |
| inv_hi_i | input | 1 | Invert the high-threshold flag |
| inv_lo_i | input | 1 | Invert the low-threshold flag |
| t1_sel_i | input | 1 | T1 source: 0 high flag, 1 low flag |
| t2_sel_i | input | 1 | T2 source: 0 high flag, 1 low flag |
| t1_act_i | input | 2 | Action on T1 event |
| t2_act_i | input | 2 | Action on T2 event |
| red_i | input | DLY_W | Rising-edge delay of A, in clocks |
| fed_i | input | DLY_W | Falling-edge delay (rise of B), in clocks |
| trip_i | input | 1 | Trip request |
| trip_clr_i | input | 1 | Trip latch release |
| trip_b_lvl_i | input | 1 | Level forced on B while tripped |
| pwm_a_o | output | 1 | Main switch drive |
| pwm_b_o | output | 1 | Complementary switch drive |

## Verification
The collision that matters most is T1 and T2 firing in the same cycle. The bench provokes it by raising both comparator flags on the same clock. It first checks that the set action of T2 wins. It then sets the T2 action to none and repeats, checking that the T1 clear applies. The second collision is a switch-off event landing inside a running rising-edge delay. The bench provokes it by raising the high flag two cycles after the low flag with a long delay programmed. It then checks that A never rises and that B still follows its own falling-edge delay.

// File: rtl/cmp_pwm_pkg.sv
`timescale 1ns/1ps
package cmp_pwm_pkg;
  typedef enum logic [1:0] {
    AQ_NONE = 2'b00,
    AQ_CLR  = 2'b01,
    AQ_SET  = 2'b10,
    AQ_TGL  = 2'b11
  } aq_act_e;

  function automatic logic aq_apply(aq_act_e act, logic cur);
    case (act)
      AQ_CLR:  return 1'b0;
      AQ_SET:  return 1'b1;
      AQ_TGL:  return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_evt_sync.sv
`timescale 1ns/1ps
module cmp_evt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic inv_i,
  output logic evt_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], lvl_i ^ inv_i};
  end

  // one pulse per newly asserted level
  assign evt_o = sh_q[SH_W-2] & ~sh_q[SH_W-1];
endmodule

// File: rtl/cmp_aq.sv
`timescale 1ns/1ps
module cmp_aq
  import cmp_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_hi_i,
  input  logic       ev_lo_i,
  input  logic       t1_sel_i,
  input  logic       t2_sel_i,
  input  logic [1:0] t1_act_i,
  input  logic [1:0] t2_act_i,
  output logic       sw_o
);
  aq_act_e act1, act2;
  logic    t1_ev, t2_ev, sw_q, sw_d;

  assign act1  = aq_act_e'(t1_act_i);
  assign act2  = aq_act_e'(t2_act_i);
  assign t1_ev = t1_sel_i ? ev_lo_i : ev_hi_i;
  assign t2_ev = t2_sel_i ? ev_lo_i : ev_hi_i;

  // T2 has priority over T1 when it carries an action
  always_comb begin
    sw_d = sw_q;
    if (t2_ev && act2 != AQ_NONE) sw_d = aq_apply(act2, sw_q);
    else if (t1_ev)               sw_d = aq_apply(act1, sw_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= 1'b0;
    else         sw_q <= sw_d;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/cmp_deadband.sv
`timescale 1ns/1ps
module cmp_deadband #(
  parameter int DLY_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_i,
  input  logic [DLY_W-1:0] red_i,
  input  logic [DLY_W-1:0] fed_i,
  output logic             a_o,
  output logic             b_o
);
  logic [DLY_W-1:0] rcnt_q, fcnt_q;

  // elapsed-time counters, saturating at the programmed delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      fcnt_q <= '1;
    end else begin
      if (!sw_i)              rcnt_q <= '0;
      else if (rcnt_q < red_i) rcnt_q <= rcnt_q + 1'b1;
      if (sw_i)               fcnt_q <= '0;
      else if (fcnt_q < fed_i) fcnt_q <= fcnt_q + 1'b1;
    end
  end

  assign a_o = sw_i  & (rcnt_q >= red_i);
  assign b_o = ~sw_i & (fcnt_q >= fed_i);
endmodule

// File: rtl/cmp_trip.sv
`timescale 1ns/1ps
module cmp_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic clr_i,
  input  logic lvl_i,
  input  logic a_i,
  input  logic b_i,
  output logic a_o,
  output logic b_o,
  output logic tripped_o
);
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              latch_q <= 1'b0;
    else if (trip_i)          latch_q <= 1'b1;
    else if (clr_i)           latch_q <= 1'b0;
  end

  assign tripped_o = latch_q | trip_i;
  assign a_o       = tripped_o ? 1'b0  : a_i;
  assign b_o       = tripped_o ? lvl_i : b_i;
endmodule

// File: rtl/cmp_pwm_stage.sv
`timescale 1ns/1ps
module cmp_pwm_stage #(
  parameter int DLY_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_hi_i,
  input  logic             cmp_lo_i,
  input  logic             inv_hi_i,
  input  logic             inv_lo_i,
  input  logic             t1_sel_i,
  input  logic             t2_sel_i,
  input  logic [1:0]       t1_act_i,
  input  logic [1:0]       t2_act_i,
  input  logic [DLY_W-1:0] red_i,
  input  logic [DLY_W-1:0] fed_i,
  input  logic             trip_i,
  input  logic             trip_clr_i,
  input  logic             trip_b_lvl_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int N_CMP = 2;

  logic [N_CMP-1:0] cmp_lvl, cmp_inv, ev;
  logic ev_hi, ev_lo, sw_q, a_db, b_db, tripped;

  assign cmp_lvl = {cmp_lo_i, cmp_hi_i};
  assign cmp_inv = {inv_lo_i, inv_hi_i};

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    cmp_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (cmp_lvl[g]),
      .inv_i (cmp_inv[g]),
      .evt_o (ev[g])
    );
  end

  assign ev_hi = ev[0];
  assign ev_lo = ev[1];

  cmp_aq u_aq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_hi_i (ev_hi),
    .ev_lo_i (ev_lo),
    .t1_sel_i(t1_sel_i),
    .t2_sel_i(t2_sel_i),
    .t1_act_i(t1_act_i),
    .t2_act_i(t2_act_i),
    .sw_o    (sw_q)
  );

  cmp_deadband #(.DLY_W(DLY_W)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sw_i  (sw_q),
    .red_i (red_i),
    .fed_i (fed_i),
    .a_o   (a_db),
    .b_o   (b_db)
  );

  cmp_trip u_trip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trip_i   (trip_i),
    .clr_i    (trip_clr_i),
    .lvl_i    (trip_b_lvl_i),
    .a_i      (a_db),
    .b_i      (b_db),
    .a_o      (pwm_a_o),
    .b_o      (pwm_b_o),
    .tripped_o(tripped)
  );
endmodule

// File: rtl/cmp_pwm_chk.sv
`timescale 1ns/1ps
module cmp_pwm_chk #(
  parameter int DLY_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trip_i,
  input logic             trip_clr_i,
  input logic             trip_b_lvl_i,
  input logic [DLY_W-1:0] red_i,
  input logic             pwm_a_o,
  input logic             pwm_b_o,
  input logic             ev_hi,
  input logic             ev_lo,
  input logic             sw,
  input logic             a_db,
  input logic             b_db
);
  assert_hi_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_hi |=> !ev_hi);
  assert_lo_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lo |=> !ev_lo);
  assert_red_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red_i == '0 && $rose(sw)) |-> a_db);
  assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw) |-> !a_db);
  assert_b_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw) |-> !b_db);
  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_db && b_db));
  assert_trip_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |-> (!pwm_a_o && pwm_b_o == trip_b_lvl_i));
  assert_trip_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(trip_i) && !$past(trip_clr_i)) |-> !pwm_a_o);
endmodule

bind cmp_pwm_stage cmp_pwm_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trip_i      (trip_i),
  .trip_clr_i  (trip_clr_i),
  .trip_b_lvl_i(trip_b_lvl_i),
  .red_i       (red_i),
  .pwm_a_o     (pwm_a_o),
  .pwm_b_o     (pwm_b_o),
  .ev_hi       (ev_hi),
  .ev_lo       (ev_lo),
  .sw          (sw_q),
  .a_db        (a_db),
  .b_db        (b_db)
);

// File: tb/sim_cmp_pwm_stage.sv
`timescale 1ns/1ps
module sim_cmp_pwm_stage;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_ni;
  logic       cmp_hi, cmp_hi1, cmp_lo, inv_hi, inv_lo, t1_sel, t2_sel;
  logic [1:0] t1_act, t2_act;
  logic [9:0] red, fed;
  logic       trip, trip_clr, trip_lvl;
  logic       pwm_a, pwm_b, pwm_a1, pwm_b1;

  cmp_pwm_stage u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
    .inv_hi_i(inv_hi), .inv_lo_i(inv_lo), .t1_sel_i(t1_sel), .t2_sel_i(t2_sel),
    .t1_act_i(t1_act), .t2_act_i(t2_act), .red_i(red), .fed_i(fed),
    .trip_i(trip), .trip_clr_i(trip_clr), .trip_b_lvl_i(trip_lvl),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  // second phase sharing the low-threshold event
  cmp_pwm_stage u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_hi_i(cmp_hi1), .cmp_lo_i(cmp_lo),
    .inv_hi_i(inv_hi), .inv_lo_i(inv_lo), .t1_sel_i(t1_sel), .t2_sel_i(t2_sel),
    .t1_act_i(t1_act), .t2_act_i(t2_act), .red_i(red), .fed_i(fed),
    .trip_i(trip), .trip_clr_i(trip_clr), .trip_b_lvl_i(trip_lvl),
    .pwm_a_o(pwm_a1), .pwm_b_o(pwm_b1)
  );

  int cyc;
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    a;
    bit    b;
    bit    a1;
    bit    pair;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;

  task automatic expect_at(int dly, bit a, bit b, string tag);
    exp_t e;
    e.at = cyc + dly; e.a = a; e.b = b; e.a1 = 1'b0; e.pair = 1'b0; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic expect_pair(int dly, bit a, bit a1, string tag);
    exp_t e;
    e.at = cyc + dly; e.a = a; e.b = 1'b0; e.a1 = a1; e.pair = 1'b1; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  // monitor: compare once outputs have settled after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (e.at != cyc) begin
          n_fail++;
          $display("FAIL %s: check missed, cycle %0d expected %0d", e.tag, cyc, e.at);
        end else if (e.pair) begin
          if (pwm_a !== e.a || pwm_a1 !== e.a1) begin
            n_fail++;
            $display("FAIL %s: cyc %0d a0=%0b a1=%0b expected a0=%0b a1=%0b",
                     e.tag, cyc, pwm_a, pwm_a1, e.a, e.a1);
          end
        end else if (pwm_a !== e.a || pwm_b !== e.b) begin
          n_fail++;
          $display("FAIL %s: cyc %0d a=%0b b=%0b expected a=%0b b=%0b",
                   e.tag, cyc, pwm_a, pwm_b, e.a, e.b);
        end
      end
    end
  end

  initial begin
    #250000;
    n_fail++;
    $display("FAIL watchdog: run not finished, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    cmp_hi = 0; cmp_hi1 = 0; cmp_lo = 0; inv_hi = 0; inv_lo = 0;
    t1_sel = 1'b0; t1_act = 2'b01; t2_sel = 1'b1; t2_act = 2'b10;
    red = '0; fed = '0; trip = 0; trip_clr = 0; trip_lvl = 0;
    tick(3);
    rst_ni = 1'b1;

    // R1 reset state
    expect_at(1, 0, 1, "R1");
    drain();

    // R2 low flag sets switch on third edge; R4 high flag clears
    cmp_lo = 1;
    expect_at(2, 0, 1, "R2");
    expect_at(3, 1, 0, "R2");
    drain();
    cmp_lo = 0;
    tick(3);
    cmp_hi = 1;
    expect_at(2, 1, 0, "R4");
    expect_at(3, 0, 1, "R4");
    drain();
    cmp_hi = 0;
    tick(3);

    // R6 rising delay 4, R8 falling delay 3
    red = 10'd4; fed = 10'd3;
    tick(1);
    cmp_lo = 1;
    expect_at(3, 0, 0, "R8");
    expect_at(6, 0, 0, "R6");
    expect_at(7, 1, 0, "R6");
    drain();
    cmp_lo = 0;
    tick(2);
    cmp_hi = 1;
    expect_at(3, 0, 0, "R8");
    expect_at(5, 0, 0, "R8");
    expect_at(6, 0, 1, "R8");
    drain();
    cmp_hi = 0;
    tick(2);

    // R7 switch-off lands inside the rising delay
    red = 10'd8;
    tick(1);
    cmp_lo = 1;
    expect_at(4, 0, 0, "R7");
    expect_at(8, 0, 1, "R7");
    expect_at(11, 0, 1, "R7");
    expect_at(12, 0, 1, "R7");
    tick(2);
    cmp_hi = 1;
    drain();
    cmp_lo = 0; cmp_hi = 0;
    tick(2);

    // R5 T1 and T2 in the same cycle
    red = '0; fed = '0;
    tick(1);
    cmp_hi = 1; cmp_lo = 1;
    expect_at(3, 1, 0, "R5");
    drain();
    cmp_hi = 0; cmp_lo = 0;
    tick(3);
    t2_act = 2'b00;
    tick(1);
    cmp_hi = 1; cmp_lo = 1;
    expect_at(3, 0, 1, "R5");
    drain();
    cmp_hi = 0; cmp_lo = 0; t2_act = 2'b10;
    tick(3);

    // R3 inversion: no event when inverted level is unchanged
    inv_lo = 1; cmp_lo = 1;
    expect_at(3, 0, 1, "R3");
    expect_at(5, 0, 1, "R3");
    drain();
    cmp_lo = 0;
    expect_at(3, 1, 0, "R3");
    drain();

    // R4 toggle action
    t1_act = 2'b11;
    cmp_hi = 1;
    expect_at(3, 0, 1, "R4");
    drain();
    cmp_hi = 0;
    tick(3);
    cmp_hi = 1;
    expect_at(3, 1, 0, "R4");
    drain();
    cmp_hi = 0; t1_act = 2'b01;
    inv_lo = 0;
    expect_at(4, 1, 0, "R3");
    drain();

    // R9 trip forces outputs, R10 latch and release
    trip_lvl = 1;
    tick(1);
    trip = 1;
    expect_at(1, 0, 1, "R9");
    tick(1);
    trip = 0;
    expect_at(2, 0, 1, "R10");
    tick(2);
    trip_lvl = 0;
    expect_at(1, 0, 0, "R10");
    tick(1);
    trip = 1; trip_clr = 1;
    tick(1);
    trip = 0; trip_clr = 0;
    expect_at(2, 0, 0, "R10");
    tick(2);
    trip_clr = 1;
    tick(1);
    trip_clr = 0;
    expect_at(1, 1, 0, "R10");
    drain();

    // R11 two phases on a shared event
    cmp_hi = 1; cmp_hi1 = 1;
    expect_pair(3, 0, 0, "R11");
    drain();
    cmp_hi = 0; cmp_hi1 = 0;
    tick(2);
    cmp_lo = 1;
    expect_pair(2, 0, 0, "R11");
    expect_pair(3, 1, 1, "R11");
    drain();
    cmp_lo = 0;
    tick(2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule